// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Model

This block is a synthesizable, cycle-based model of a byte-wide non-volatile memory that behaves like a static RAM on the bus. A host uses three active-low strobes, an address and a byte of data. The host can load anywhere from one to a full page of bytes. The block keeps those bytes and their offsets in an internal page buffer, so the bus is free again at once. When no further write strobe arrives within a load window, an internal timer commits the buffered bytes to the array with no further bus traffic.

While a load or commit is under way, a read does not return array contents. It returns an in-band status byte instead. Bit 7 is the inverse of bit 7 of the last byte accepted, and bit 6 flips on every new read. Software detects completion when bit 7 reads back true, or when bit 6 stops changing.

Several gates stand in front of writes. A write is refused while the read strobe is low. For a set time after the supply-good flag rises, all writes are locked out. Write strobes shorter than a minimum width in clock cycles are rejected. The top page of the address space can be switched to a separate 64-byte identification store by a digital high-voltage flag. Array size, page size and all timings are parameters. The defaults use a reduced array and short timers so that the model elaborates quickly; the full 32K part uses `ADDR_W = 15`, and a 10 ms commit takes 1,000,000 cycles at 100 MHz.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset every array and identification byte reads 0xFF. A committed byte reads back exactly as written. A page byte that was not loaded keeps its old value after the commit.
- R2: The first accepted byte of a load selects the page, which is the address bits above the low `PAGE_W` bits. Later bytes in the same page, up to the full page of 2^`PAGE_W` bytes, are buffered. Bytes addressed to any other page are discarded.
- R3: The block is busy from the first accepted write strobe until `LOAD_WIN` + `WRITE_CYCLES` rising clock edges after the last accepted write strobe. Any accepted strobe restarts the load window. Write strobes that arrive during the commit phase change nothing.
- R4: A read sampled while the block is busy returns {~L[7], T, L[5:0]}, where L is the last byte accepted and T is the toggle bit. A read after the busy period returns the true array byte.
- R5: While the block is busy, the toggle bit starts at 0 when the busy period begins and inverts at the first edge of each new read (select low and read strobe low). The first status read of a busy period therefore shows bit 6 = 1, the second shows 0, and so on.
- R6: A write strobe (select low, write strobe low) is never accepted while the read strobe is low.
- R7: The block accepts no write until `POR_CYCLES` clock edges have passed with `pwr_good` high. Dropping `pwr_good` restarts this lockout.
- R8: A write strobe is accepted once, at the `MIN_PULSE`-th consecutive rising edge at which select and write strobe are both low. A strobe that is held for fewer edges is ignored.
- R9: While `id_unlock` is high, reads and writes to the top page (all address bits above the offset set to one) go to a separate 64-byte identification store. While `id_unlock` is low, the same addresses reach the main array.
- R10: Read data and `rdat_oe` are registered. At the clock edge after a read strobe is sampled, they show the result for that edge's address. `rdat_oe` is low when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| rd_n | input | 1 | Active-low read strobe / output enable |
| wr_n | input | 1 | Active-low write strobe |
| loc | input | ADDR_W | Byte address |
| wdat | input | 8 | Write data (inbound half of the data bus) |
| rdat | output | 8 | Read data or status (outbound half of the data bus) |
| rdat_oe | output | 1 | Drive enable for `rdat` |
| pwr_good | input | 1 | Supply-good flag |
| id_unlock | input | 1 | High-voltage flag that maps the top page to the ID store |

## Verification
The bench counts the rising edges. It notes the edge at which each accepted strobe fires, which is the `MIN_PULSE`-th edge of the strobe. From that edge it derives the edge at which the busy period ends, `LOAD_WIN` + `WRITE_CYCLES` later. A read that starts on the falling edge before edge k reflects the state just before edge k, and it is sampled at the following falling edge. One read is placed so that it is sampled at exactly the last busy edge, where it must still return status, and the next read must return true data. Toggle reads are placed back to back inside the load window. Writes that must be ignored are each followed at once by a read, made before any other write.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_strobe_filter.sv
module pw_strobe_filter #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic fire_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!act_i)
      cnt_d = '0;
    else if (cnt_q != CW'(MIN_PULSE))
      cnt_d = cnt_q + 1'b1;
  end

  assign fire_o = act_i && (cnt_q == CW'(MIN_PULSE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one acceptance per strobe, never on consecutive edges
  assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/pw_por_lock.sv
module pw_por_lock #(
  parameter int POR_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  output logic locked_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = pwr_ok_i && (cnt_q != CW'(POR_CYCLES));

  always_comb begin
    cnt_d = cnt_q;
    if (!pwr_ok_i)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  assign locked_o = !(pwr_ok_i && (cnt_q == CW'(POR_CYCLES)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_rise_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok_i) |-> locked_o);
endmodule

// File: rtl/pw_page_ctrl.sv
module pw_page_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 6,
  parameter int LOAD_WIN     = 20,
  parameter int WRITE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              id_flag_i,
  output logic              busy_o,
  output logic [7:0]        last_o,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [7:0]        cm_data_o,
  output logic              cm_id_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TAG_W  = ADDR_W - PAGE_W;
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int PRG_W  = $clog2(WRITE_CYCLES + 1);

  pw_state_e          state_q, state_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               id_q, id_d;
  logic [WIN_W-1:0]   win_q, win_d;
  logic [PRG_W-1:0]   prg_q, prg_d;
  logic [7:0]         last_q, last_d;
  logic [PAGE_N-1:0]  vld_q, vld_d;
  logic [7:0]         buf_q [PAGE_N];
  logic               buf_we;

  logic               accept;
  logic [TAG_W-1:0]   in_tag;
  logic [PAGE_W-1:0]  in_off;
  logic               in_id;
  logic [PAGE_W-1:0]  cm_idx;

  assign accept = fire_i && !locked_i;
  assign in_tag = addr_i[ADDR_W-1:PAGE_W];
  assign in_off = addr_i[PAGE_W-1:0];
  assign in_id  = id_flag_i && (&in_tag);

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    id_d    = id_q;
    win_d   = win_q;
    prg_d   = prg_q;
    last_d  = last_q;
    vld_d   = vld_q;
    buf_we  = 1'b0;
    case (state_q)
      PW_IDLE: begin
        if (accept) begin
          tag_d          = in_tag;
          id_d           = in_id;
          vld_d          = '0;
          vld_d[in_off]  = 1'b1;
          buf_we         = 1'b1;
          last_d         = data_i;
          win_d          = '0;
          state_d        = PW_LOAD;
        end
      end
      PW_LOAD: begin
        if (accept) begin
          win_d = '0;
          if (in_tag == tag_q && in_id == id_q) begin
            vld_d[in_off] = 1'b1;
            buf_we        = 1'b1;
            last_d        = data_i;
          end
        end else if (win_q == WIN_W'(LOAD_WIN - 1)) begin
          prg_d   = '0;
          state_d = PW_PROG;
        end else begin
          win_d = win_q + 1'b1;
        end
      end
      PW_PROG: begin
        if (prg_q == PRG_W'(WRITE_CYCLES - 1)) begin
          vld_d   = '0;
          state_d = PW_IDLE;
        end else begin
          prg_d = prg_q + 1'b1;
        end
      end
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      tag_q   <= '0;
      id_q    <= 1'b0;
      win_q   <= '0;
      prg_q   <= '0;
      last_q  <= '0;
      vld_q   <= '0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
      id_q    <= id_d;
      win_q   <= win_d;
      prg_q   <= prg_d;
      last_q  <= last_d;
      vld_q   <= vld_d;
    end
  end

  // page buffer data needs no reset: only entries flagged valid are used
  always_ff @(posedge clk) begin
    if (buf_we) buf_q[in_off] <= data_i;
  end

  // commit walks the page one offset per cycle at the start of programming
  assign cm_idx    = prg_q[PAGE_W-1:0];
  assign cm_we_o   = (state_q == PW_PROG) && (prg_q < PRG_W'(PAGE_N)) && vld_q[cm_idx];
  assign cm_addr_o = {tag_q, cm_idx};
  assign cm_data_o = buf_q[cm_idx];
  assign cm_id_o   = id_q;
  assign busy_o    = (state_q != PW_IDLE);
  assign last_o    = last_q;

  assert_locked_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_IDLE && fire_i && locked_i) |=> (state_q == PW_IDLE));

  assert_prog_ignores_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_PROG && fire_i) |=> $stable(last_q));

  assert_load_starts_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_IDLE && accept) |=> busy_o);
endmodule

// File: rtl/pw_array.sv
module pw_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wid_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              rid_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ID_N   = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] id_q  [ID_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i && !wid_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ID_N; i++) id_q[i] <= 8'hFF;
    end else if (we_i && wid_i) begin
      id_q[waddr_i[PAGE_W-1:0]] <= wdata_i;
    end
  end

  assign rdata_o = rid_i ? id_q[raddr_i[PAGE_W-1:0]] : mem_q[raddr_i];

  assert_commit_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !$isunknown(wdata_i));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 6,
  parameter int LOAD_WIN     = 20,
  parameter int WRITE_CYCLES = 200,
  parameter int POR_CYCLES   = 100,
  parameter int MIN_PULSE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] loc,
  input  logic [7:0]        wdat,
  output logic [7:0]        rdat,
  output logic              rdat_oe,
  input  logic              pwr_good,
  input  logic              id_unlock
);
  logic              wr_act, rd_act, rd_start;
  logic              wr_fire, locked, busy;
  logic [7:0]        last_byte, arr_rdata;
  logic              cm_we, cm_id, rd_id;
  logic [ADDR_W-1:0] cm_addr;
  logic [7:0]        cm_data;

  logic              rd_q, tog_q, tog_d, oe_q;
  logic [7:0]        rdat_q, rdat_d;

  // write inhibited whenever the read strobe is low
  assign wr_act = !sel_n && !wr_n && rd_n;
  assign rd_act = !sel_n && !rd_n;
  assign rd_id  = id_unlock && (&loc[ADDR_W-1:PAGE_W]);

  pw_strobe_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst_n(rst_n), .act_i(wr_act), .fire_o(wr_fire)
  );

  pw_por_lock #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_good), .locked_o(locked)
  );

  pw_page_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .LOAD_WIN(LOAD_WIN), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fire_i(wr_fire), .locked_i(locked),
    .addr_i(loc), .data_i(wdat), .id_flag_i(id_unlock),
    .busy_o(busy), .last_o(last_byte),
    .cm_we_o(cm_we), .cm_addr_o(cm_addr), .cm_data_o(cm_data), .cm_id_o(cm_id)
  );

  pw_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we_i(cm_we), .waddr_i(cm_addr), .wdata_i(cm_data), .wid_i(cm_id),
    .raddr_i(loc), .rid_i(rd_id), .rdata_o(arr_rdata)
  );

  assign rd_start = rd_act && !rd_q;

  always_comb begin
    tog_d = tog_q;
    if (!busy)         tog_d = 1'b0;
    else if (rd_start) tog_d = ~tog_q;
    rdat_d = rdat_q;
    if (rd_act)
      rdat_d = busy ? {~last_byte[7], tog_d, last_byte[5:0]} : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      tog_q  <= 1'b0;
      oe_q   <= 1'b0;
      rdat_q <= 8'h00;
    end else begin
      rd_q   <= rd_act;
      tog_q  <= tog_d;
      oe_q   <= rd_act;
      rdat_q <= rdat_d;
    end
  end

  assign rdat    = rdat_q;
  assign rdat_oe = oe_q;

  assert_oe_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !wr_fire);

  assert_status_inverts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && busy) |=> (rdat[7] != $past(last_byte[7])));

  assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy && $past(busy)) |=> (rdat[6] != $past(tog_q)));
endmodule

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int ADDR_W       = 11;
  localparam int PAGE_W       = 6;
  localparam int LOAD_WIN     = 20;
  localparam int WRITE_CYCLES = 200;
  localparam int POR_CYCLES   = 100;
  localparam int MIN_PULSE    = 2;
  localparam int PAGE_N       = 1 << PAGE_W;
  localparam int NPAGES       = 1 << (ADDR_W - PAGE_W);
  localparam int DEPTH        = 1 << ADDR_W;

  logic              clk, rst_n, sel_n, rd_n, wr_n, pwr_good, id_unlock;
  logic [ADDR_W-1:0] loc;
  logic [7:0]        wdat, rdat;
  logic              rdat_oe;

  int n_chk, n_bad, cyc;
  bit done;
  logic [7:0] ref_mem [DEPTH];

  eeprom_page_writer #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LOAD_WIN(LOAD_WIN),
    .WRITE_CYCLES(WRITE_CYCLES), .POR_CYCLES(POR_CYCLES), .MIN_PULSE(MIN_PULSE)
  ) u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .loc(loc), .wdat(wdat), .rdat(rdat), .rdat_oe(rdat_oe),
    .pwr_good(pwr_good), .id_unlock(id_unlock)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] status_of(input logic [7:0] last, input logic t);
    return {~last[7], t, last[5:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int page, input int off);
    return ADDR_W'(page * PAGE_N + off);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entered and left on a falling edge; fire = edge count when the strobe is accepted
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int w,
                    output int fire);
    loc = a; wdat = d; sel_n = 1'b0; wr_n = 1'b0;
    fire = cyc + MIN_PULSE;
    repeat (w) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic oe);
    loc = a; sel_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    v = rdat; oe = rdat_oe;
    sel_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int f, lastf, seed;
    logic [7:0] v;
    logic oe;
    n_chk = 0; n_bad = 0; done = 1'b0;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    loc = '0; wdat = '0; pwr_good = 1'b0; id_unlock = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: no drive when idle; R1: reset contents
    check("R10 idle drive", {7'd0, rdat_oe}, 8'd0);
    rd(mk(0, 0), v, oe);
    check("R1 reset value", v, 8'hFF);
    check("R10 drive during read", {7'd0, oe}, 8'd1);

    // R7: write right after supply-good rises is locked out
    pwr_good = 1'b1;
    wr(mk(2, 5), 8'h12, 3, f);
    rd(mk(2, 5), v, oe);
    check("R7 lockout", v, 8'hFF);
    wait_until(cyc + POR_CYCLES + 5);

    // R8: too-short strobe ignored
    wr(mk(2, 5), 8'h12, MIN_PULSE - 1, f);
    rd(mk(2, 5), v, oe);
    check("R8 short strobe", v, 8'hFF);

    // R6: write with read strobe low ignored
    loc = mk(2, 5); wdat = 8'h12; sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    rd(mk(2, 5), v, oe);
    check("R6 inhibit", v, 8'hFF);

    // R2/R3/R4/R5: page 5 load with a stray byte
    wr(mk(5, 1), 8'h12, 3, f);
    wr(mk(5, 2), 8'h34, 3, f);
    wr(mk(9, 7), 8'h77, 3, f);
    wr(mk(5, 40), 8'hC5, 3, lastf);
    ref_mem[mk(5, 1)] = 8'h12; ref_mem[mk(5, 2)] = 8'h34; ref_mem[mk(5, 40)] = 8'hC5;
    rd(mk(5, 40), v, oe);
    check("R4 R5 status read 1", v, status_of(8'hC5, 1'b1));
    rd(mk(5, 40), v, oe);
    check("R5 status read 2", v, status_of(8'hC5, 1'b0));
    rd(mk(5, 40), v, oe);
    check("R5 status read 3", v, status_of(8'hC5, 1'b1));
    wait_until(lastf + LOAD_WIN + 5);
    wr(mk(5, 1), 8'hAA, 3, f);
    wait_until(lastf + LOAD_WIN + WRITE_CYCLES - 1);
    rd(mk(5, 40), v, oe);
    check("R3 R4 busy at last edge", v & 8'hBF, 8'h05);
    rd(mk(5, 40), v, oe);
    check("R4 true data after busy", v, 8'hC5);
    rd(mk(5, 1), v, oe);
    check("R3 write during commit ignored", v, 8'h12);
    rd(mk(5, 2), v, oe);
    check("R1 committed byte", v, 8'h34);
    rd(mk(5, 0), v, oe);
    check("R1 unloaded byte kept", v, 8'hFF);
    rd(mk(9, 7), v, oe);
    check("R2 off-page byte dropped", v, 8'hFF);

    // R9: identification store
    id_unlock = 1'b1;
    wr(mk(NPAGES - 1, 3), 8'h5A, 3, f);
    wait_until(f + LOAD_WIN + WRITE_CYCLES + 1);
    rd(mk(NPAGES - 1, 3), v, oe);
    check("R9 id read", v, 8'h5A);
    id_unlock = 1'b0;
    rd(mk(NPAGES - 1, 3), v, oe);
    check("R9 main array untouched", v, 8'hFF);
    wr(mk(NPAGES - 1, 3), 8'h11, 3, f);
    ref_mem[mk(NPAGES - 1, 3)] = 8'h11;
    wait_until(f + LOAD_WIN + WRITE_CYCLES + 1);
    id_unlock = 1'b1;
    rd(mk(NPAGES - 1, 3), v, oe);
    check("R9 id kept", v, 8'h5A);
    id_unlock = 1'b0;
    rd(mk(NPAGES - 1, 3), v, oe);
    check("R9 main written", v, 8'h11);

    // R1/R2: random page loads, the first one a full page
    for (int it = 0; it < 5; it++) begin
      int pg, n, off;
      logic [7:0] d;
      pg = $urandom_range(0, NPAGES - 2);
      n  = (it == 0) ? PAGE_N : $urandom_range(1, 6);
      for (int k = 0; k < n; k++) begin
        off = (it == 0) ? k : $urandom_range(0, PAGE_N - 1);
        d   = 8'($urandom);
        wr(mk(pg, off), d, $urandom_range(MIN_PULSE, MIN_PULSE + 2), lastf);
        ref_mem[mk(pg, off)] = d;
      end
      wait_until(lastf + LOAD_WIN + WRITE_CYCLES + 1);
      for (int k = 0; k < PAGE_N; k++) begin
        rd(mk(pg, k), v, oe);
        check("R1 R2 random page readback", v, ref_mem[mk(pg, k)]);
      end
    end

    finish_run();
  end
endmodule